// File: doc/BRIEF.md
# Burst Address Generator

This block produces the word address for a synchronous memory that supports four-beat bursts. A base address is captured from the external address bus whenever either of two start strobes is high at a rising clock edge. While no strobe is present, an advance input steps an internal beat counter. The two least significant address bits then follow a sequence derived from the captured low bits. The upper address bits stay at their captured value for the whole burst.

The beat sequence is set by a mode pin. In linear mode the low bits count upward modulo four from the start value. In interleaved mode the low bits are the start value XOR the beat number. After the fourth beat the sequence wraps inside the same aligned four-word block. Bursting is optional: raising a strobe on every cycle loads a fresh address every cycle, with no idle cycle in between. The block has no data path, so all its pins are plain control and address signals and nothing carries a valid/ready handshake.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the register behind `addr_out` clears, and `addr_out` reads zero after that edge.
- R2: When `start_a` is high at a rising edge, `addr_out` equals the `addr_in` value sampled at that edge from that edge onward, until the next change.
- R3: `start_b` behaves the same way as `start_a`: when high at a rising edge, it loads `addr_in` into `addr_out`.
- R4: With `order_sel` = 0 (linear), each edge with `advance` high and both strobes low adds one, modulo 4, to the two low bits of `addr_out`.
- R5: With `order_sel` = 1 (interleaved), the two low bits of `addr_out` on beat k (k = 0..3, counted from the load) equal the loaded low bits XOR k.
- R6: An edge with both strobes low and `advance` low leaves `addr_out` unchanged.
- R7: After four advances the beat count wraps, so `addr_out` returns to the loaded address in either order.
- R8: A strobe and `advance` both high at the same edge reload the base address and restart the count at beat 0; the advance is ignored.
- R9: The bits of `addr_out` above bit 1 change only on an edge where a strobe is high.
- R10: Strobes on consecutive edges load a new address on each of those edges, without a stall cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | External address, sampled when a strobe is high |
| start_a | input | 1 | First burst-start strobe |
| start_b | input | 1 | Second burst-start strobe |
| advance | input | 1 | Step to the next beat when no strobe is high |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_out | output | ADDR_W | Current internal address |

## Verification
The assertions assume that `order_sel` is a static strap. A check that `addr_out` holds therefore excuses any cycle in which `order_sel` itself moved. The stimulus follows this assumption: the random phase changes `order_sel` only on cycles that also raise a strobe, so every burst runs under a single order. The directed cases check that a strobe wins over `advance`, that the count wraps after four beats, and that loads can come on every cycle.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int BEAT_W = 2;
  typedef enum logic { ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1 } order_e;
endpackage

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [CNT_W-1:0] beat
);
  always_ff @(posedge clk) begin
    if (!rst_n)    beat <= '0;
    else if (load) beat <= '0;
    else if (step) beat <= beat + CNT_W'(1);
  end

  // R8
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> beat == '0);

  // R4
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> beat == $past(beat) + CNT_W'(1));

  // R6
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(beat));
endmodule

// File: rtl/bag_base_reg.sv
module bag_base_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n)    base <= '0;
    else if (load) base <= addr_in;
  end

  // R9
  base_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base));
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
  import bag_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_low,
  input  logic [CNT_W-1:0] beat,
  input  order_e           order,
  output logic [CNT_W-1:0] low_out
);
  logic [CNT_W-1:0] lin_low;
  logic [CNT_W-1:0] ilv_low;

  assign lin_low = start_low + beat;

  for (genvar i = 0; i < CNT_W; i++) begin : g_ilv
    assign ilv_low[i] = start_low[i] ^ beat[i];
  end

  always_comb begin
    unique case (order)
      ORD_INTERLEAVE: low_out = ilv_low;
      default:        low_out = lin_low;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              start_a,
  input  logic              start_b,
  input  logic              advance,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int CNT_W = BEAT_W;
  localparam int HI_W  = ADDR_W - CNT_W;

  logic              load;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  beat;
  logic [CNT_W-1:0]  low;
  order_e            order;

  assign load  = start_a | start_b;
  assign order = order_e'(order_sel);

  bag_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk(clk), .rst_n(rst_n), .load(load), .addr_in(addr_in), .base(base)
  );

  bag_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(advance), .beat(beat)
  );

  bag_order_map #(.CNT_W(CNT_W)) u_map (
    .start_low(base[CNT_W-1:0]), .beat(beat), .order(order), .low_out(low)
  );

  assign addr_out = {base[ADDR_W-1:CNT_W], low};

  // R2
  load_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_a |=> addr_out == $past(addr_in));

  // R3
  load_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_b |=> addr_out == $past(addr_in));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> (order_sel != $past(order_sel)) || $stable(addr_out));

  // R9
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W]));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance && !order_sel) |=>
      (order_sel || addr_out[CNT_W-1:0] == $past(addr_out[CNT_W-1:0]) + CNT_W'(1)));

  initial assert (HI_W >= 1) else $error("ADDR_W too small");
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          start_a = 1'b0, start_b = 1'b0, advance = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] addr_out;

  int total = 0, bad = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .start_a(start_a),
    .start_b(start_b), .advance(advance), .order_sel(order_sel), .addr_out(addr_out)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] b, logic [1:0] k, logic o);
    logic [1:0] lo;
    lo = o ? (b[1:0] ^ k) : (b[1:0] + k);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic sa, logic sb, logic adv, logic [AW-1:0] a, logic o, string tag);
    @(negedge clk);
    start_a = sa; start_b = sb; advance = adv; addr_in = a; order_sel = o;
    @(posedge clk);
    if (sa || sb) begin m_base = a; m_beat = 2'd0; end
    else if (adv) m_beat = m_beat + 2'd1;
    #1;
    check(tag, addr_out, expect_addr(m_base, m_beat, o));
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic o;
    logic [AW-1:0] prev;
    addr_in = 20'hABCDE;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", addr_out, '0);
    @(negedge clk); rst_n = 1'b1;

    step(1, 0, 0, 20'h12345, 0, "R2 load via start_a");
    step(0, 1, 0, 20'h5A5A6, 0, "R3 load via start_b");
    step(0, 0, 0, 20'hFFFFF, 0, "R6 hold");
    check("R6 hold value", addr_out, 20'h5A5A6);

    step(1, 0, 0, 20'h00101, 0, "R2 linear start");
    step(0, 0, 1, '0, 0, "R4 linear beat1");
    check("R4 linear beat1 value", addr_out, 20'h00102);
    step(0, 0, 1, '0, 0, "R4 linear beat2");
    step(0, 0, 1, '0, 0, "R4 linear beat3");
    check("R4 linear wrap in block", addr_out, 20'h00100);
    step(0, 0, 1, '0, 0, "R7 linear wrap");
    check("R7 linear back to start", addr_out, 20'h00101);

    step(0, 1, 0, 20'h0F0F1, 1, "R3 interleave start");
    step(0, 0, 1, '0, 1, "R5 ilv beat1");
    check("R5 ilv beat1 value", addr_out, 20'h0F0F0);
    step(0, 0, 1, '0, 1, "R5 ilv beat2");
    check("R5 ilv beat2 value", addr_out, 20'h0F0F3);
    step(0, 0, 1, '0, 1, "R5 ilv beat3");
    check("R5 ilv beat3 value", addr_out, 20'h0F0F2);
    step(0, 0, 1, '0, 1, "R7 ilv wrap");
    check("R7 ilv back to start", addr_out, 20'h0F0F1);

    step(0, 0, 1, '0, 1, "R5 ilv advance");
    step(1, 0, 1, 20'h33332, 1, "R8 strobe beats advance");
    check("R8 reload value", addr_out, 20'h33332);
    step(0, 1, 1, 20'h44447, 0, "R8 start_b beats advance");
    check("R8 reload b value", addr_out, 20'h44447);

    for (int i = 0; i < 6; i++) begin
      step(i[0], ~i[0], 0, AW'(20'h10000 + i * 5), 0, "R10 back-to-back load");
      check("R10 load value", addr_out, AW'(20'h10000 + i * 5));
    end

    void'($urandom(32'd1234));
    o = 1'b0;
    for (int i = 0; i < 400; i++) begin
      logic sa, sb, adv;
      logic [AW-1:0] a;
      sa  = ($urandom % 5) == 0;
      sb  = ($urandom % 6) == 0;
      adv = ($urandom % 3) != 0;
      a   = AW'($urandom);
      if (sa || sb) o = $urandom % 2;
      prev = addr_out;
      step(sa, sb, adv, a, o, (sa || sb) ? "R2 R3 random load" : (o ? "R5 random ilv" : "R4 random lin"));
      if (!(sa || sb)) check("R9 random upper fixed", {addr_out[AW-1:2], 2'b00}, {prev[AW-1:2], 2'b00});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule